// File: doc/BRIEF.md
# Glitch Parameter Sequencer

The sequencer hands a pulse engine one timing pair per fault-injection attempt: a delay (offset) and a pulse width (length), both in nanoseconds. Bounds for each come in on plain input ports. The block decides its working mode from those bounds alone, with no separate mode input.

There are three modes:
- **Sweep mode.** The two offset bounds are equal and the lower length bound is zero or positive. The offset stays at its bound. The length climbs by one on each attempt and wraps back to the lower bound after the upper bound.
- **Knob mode.** The lower length bound is negative. The length is an external 12-bit sample scaled by the upper length bound.
- **Random mode.** All other valid settings. Both values are drawn from a pseudo-random source and reduced into their ranges.

The pulse engine raises a request. After a fixed computation the block answers with a one-cycle valid strobe. The issued pair stays on the outputs until the next strobe, so it also serves as a readback of the last attempt. A combinational flag reports whether the present bounds are usable.

Top module: `glitch_param_seq`

## Requirements
- R1: `cfg_ok_o` is 1 exactly when `off_max_i >= off_min_i` (unsigned) and `len_max_i >= len_min_i` (signed 32-bit compare).
- R2: A request is accepted only while no computation is pending and `cfg_ok_o` is 1. Each accepted request produces exactly one `valid_o` pulse, one cycle long. Requests made while a computation is pending, or while `cfg_ok_o` is 0, produce no pulse.
- R3: The random source is a 32-bit Galois LFSR. One step is `s' = (s >> 1) ^ (s[0] ? 32'h80200003 : 0)`. It is loaded from `seed_i` during reset, with a zero seed replaced by 1. An accepted request uses the state `s` for the offset and `step(s)` for the length, then leaves the state at `step(step(s))`.
- R4: The issued offset is `off_min_i + (s mod (off_max_i - off_min_i))`. The modulo term is 0 when the span is 0.
- R5: Sweep mode holds when `off_min_i == off_max_i` and `len_min_i` is not negative. In sweep mode the offset equals `off_min_i`.
- R6: In sweep mode the first length after reset is `len_min_i`. Each later length is the previous one plus 1. After a length equal to `len_max_i`, the next length is `len_min_i`.
- R7: When `len_min_i` is negative, the length is `(knob_i * len_max_i) >>> 12`. The product is formed at 64-bit signed width, with `knob_i` unsigned, and the low 32 bits of the result are taken.
- R8: In random mode the length is `len_min_i + (step(s) mod (len_max_i - len_min_i))`. It equals `len_min_i` when the span is 0.
- R9: `off_o` and `len_o` change only together with a `valid_o` pulse. They hold the last issued pair until the next pulse and are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| off_min_i | input | 32 | Lower offset bound, unsigned ns |
| off_max_i | input | 32 | Upper offset bound, unsigned ns |
| len_min_i | input | 32 | Lower length bound, signed ns; negative selects knob mode |
| len_max_i | input | 32 | Upper length bound, signed ns; also the knob scale |
| seed_i | input | 32 | LFSR seed, sampled during reset |
| knob_i | input | KW (12) | External sample for knob mode |
| req_i | input | 1 | Request for a new pair |
| cfg_ok_o | output | 1 | Bounds are usable |
| valid_o | output | 1 | One-cycle strobe: a new pair is on the outputs |
| off_o | output | 32 | Issued offset, ns |
| len_o | output | 32 | Issued length, signed ns |

## Verification
The assertions assume that the bounds stay stable from reset through each run of attempts, and that a change into sweep bounds is followed by a reset. Under that assumption, the sweep-step and range properties compare each strobe against the bounds in force when it was computed. The bench meets this by setting each configuration before pulsing reset. It changes `knob_i` only while no computation is pending, and it feeds invalid bounds only to confirm that requests are refused.

// File: rtl/gps_pkg.sv
// Shared definitions for the glitch parameter sequencer.
// Assumes the data path is 32 bits wide, matching the LFSR polynomial.
package gps_pkg;
    localparam int DW = 32;
    localparam logic [DW-1:0] LFSR_TAPS = 32'h8020_0003;

    typedef enum logic {GPS_IDLE, GPS_CALC} gps_state_t;

    // One Galois step of the maximal-length 32-bit LFSR
    function automatic logic [DW-1:0] lfsr_next(input logic [DW-1:0] s);
        return {1'b0, s[DW-1:1]} ^ (s[0] ? LFSR_TAPS : '0);
    endfunction
endpackage

// File: rtl/gps_remainder.sv
// Bit-serial restoring remainder unit: dividend mod divisor in W cycles.
// Assumes start_i is only raised while busy_o is low. A zero divisor yields 0.
module gps_remainder #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [W-1:0] dividend_i,
    input  logic [W-1:0] divisor_i,
    output logic         busy_o,
    output logic [W-1:0] rem_o
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  rem_q, quo_q, div_q;
    logic [CW-1:0] cnt_q;
    logic          zero_q;
    logic [W:0]    shifted;

    // Partial remainder with the next dividend bit brought in
    always_comb shifted = {rem_q, quo_q[W-1]};

    // Load on start, then one restoring step per cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            quo_q  <= '0;
            div_q  <= '0;
            cnt_q  <= '0;
            zero_q <= 1'b1;
            busy_o <= 1'b0;
        end else if (start_i) begin
            rem_q  <= '0;
            quo_q  <= dividend_i;
            div_q  <= divisor_i;
            zero_q <= (divisor_i == '0);
            cnt_q  <= CW'(W);
            busy_o <= 1'b1;
        end else if (busy_o) begin
            if (shifted >= {1'b0, div_q})
                rem_q <= W'(shifted - {1'b0, div_q});
            else
                rem_q <= shifted[W-1:0];
            quo_q  <= quo_q << 1;
            cnt_q  <= cnt_q - 1'b1;
            busy_o <= (cnt_q != CW'(1));
        end
    end

    // The modulo term is forced to zero for an empty span
    always_comb rem_o = zero_q ? '0 : rem_q;
endmodule

// File: rtl/gps_sweep.sv
// Sweep length register: offers the next sweep length and advances on step_i.
// Assumes the bounds are stable from reset and len_max_i >= len_min_i.
module gps_sweep #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] len_min_i,
    input  logic [W-1:0] len_max_i,
    input  logic         step_i,
    output logic [W-1:0] next_o
);
    logic [W-1:0] cur_q;

    // Wrap to the lower bound after the upper bound, otherwise count up
    always_comb next_o = (cur_q == len_max_i) ? len_min_i : cur_q + 1'b1;

    // Starts one below the lower bound so the first length is the bound
    always_ff @(posedge clk) begin
        if (!rst_n)      cur_q <= len_min_i - 1'b1;
        else if (step_i) cur_q <= next_o;
    end
endmodule

// File: rtl/glitch_param_seq.sv
// Glitch parameter sequencer top.
// Picks sweep, knob or random mode from the bounds. Computes one offset/length
// pair per accepted request, with a fixed-latency remainder, and strobes valid_o.
// Assumes the bounds and knob_i are stable while a computation is pending.
module glitch_param_seq #(
    parameter int KW = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [31:0]         off_min_i,
    input  logic [31:0]         off_max_i,
    input  logic signed [31:0]  len_min_i,
    input  logic signed [31:0]  len_max_i,
    input  logic [31:0]         seed_i,
    input  logic [KW-1:0]       knob_i,
    input  logic                req_i,
    output logic                cfg_ok_o,
    output logic                valid_o,
    output logic [31:0]         off_o,
    output logic signed [31:0]  len_o
);
    import gps_pkg::*;
    localparam int PW = 2 * DW;
    localparam int NR = 2;            // remainder units: offset, length

    gps_state_t       state_q;
    logic [DW-1:0]    lfsr_q;
    logic             sweep, knob_mode, accept, finish;
    logic [DW-1:0]    off_span, len_span, sweep_len, knob_len;
    logic [DW-1:0]    len_pick;
    logic signed [PW-1:0] knob_prod;
    logic [DW-1:0]    rem_div  [NR];
    logic [DW-1:0]    rem_dsr  [NR];
    logic [DW-1:0]    rem_res  [NR];
    logic [NR-1:0]    rem_busy;

    // Bound checks and implicit mode decode
    always_comb begin
        cfg_ok_o  = (off_max_i >= off_min_i) && (len_max_i >= len_min_i);
        sweep     = (off_min_i == off_max_i) && !len_min_i[DW-1];
        knob_mode = len_min_i[DW-1];
        off_span  = off_max_i - off_min_i;
        len_span  = DW'(len_max_i - len_min_i);
        accept    = (state_q == GPS_IDLE) && req_i && cfg_ok_o;
        finish    = (state_q == GPS_CALC) && (rem_busy == '0);
    end

    // Random words for the two draws: current state and one step on
    always_comb begin
        rem_div[0] = lfsr_q;
        rem_div[1] = lfsr_next(lfsr_q);
        rem_dsr[0] = off_span;
        rem_dsr[1] = len_span;
    end

    // One remainder unit per drawn value
    for (genvar g = 0; g < NR; g++) begin : g_rem
        gps_remainder #(.W(DW)) u_rem (
            .clk       (clk),
            .rst_n     (rst_n),
            .start_i   (accept),
            .dividend_i(rem_div[g]),
            .divisor_i (rem_dsr[g]),
            .busy_o    (rem_busy[g]),
            .rem_o     (rem_res[g])
        );
    end

    gps_sweep #(.W(DW)) u_sweep (
        .clk      (clk),
        .rst_n    (rst_n),
        .len_min_i(len_min_i),
        .len_max_i(len_max_i),
        .step_i   (finish && sweep),
        .next_o   (sweep_len)
    );

    // Knob scaling at double width, unsigned sample times signed bound
    always_comb begin
        knob_prod = $signed({{(PW-KW){1'b0}}, knob_i})
                  * $signed({{DW{len_max_i[DW-1]}}, len_max_i});
        knob_len  = DW'(knob_prod >>> KW);
    end

    // Length source by mode
    always_comb begin
        if (sweep)          len_pick = sweep_len;
        else if (knob_mode) len_pick = knob_len;
        else                len_pick = len_min_i + rem_res[1];
    end

    // Request handling, LFSR advance and result register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= GPS_IDLE;
            lfsr_q  <= (seed_i == '0) ? DW'(1) : seed_i;
            valid_o <= 1'b0;
            off_o   <= '0;
            len_o   <= '0;
        end else begin
            valid_o <= 1'b0;
            case (state_q)
                GPS_IDLE: if (accept) begin
                    lfsr_q  <= lfsr_next(lfsr_next(lfsr_q));
                    state_q <= GPS_CALC;
                end
                GPS_CALC: if (finish) begin
                    off_o   <= off_min_i + rem_res[0];
                    len_o   <= len_pick;
                    valid_o <= 1'b1;
                    state_q <= GPS_IDLE;
                end
                default: state_q <= GPS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/gps_checker.sv
// Property checker for the glitch parameter sequencer, bound to the top.
// Assumes the bounds are stable from reset through each run of attempts.
module gps_checker (
    input logic               clk,
    input logic               rst_n,
    input logic [31:0]        off_min_i,
    input logic [31:0]        off_max_i,
    input logic signed [31:0] len_min_i,
    input logic signed [31:0] len_max_i,
    input logic               req_i,
    input logic               cfg_ok_o,
    input logic               valid_o,
    input logic [31:0]        off_o,
    input logic signed [31:0] len_o
);
    logic               pending_q, have_prev_q, prev_sweep_q;
    logic signed [31:0] prev_len_q;
    logic               in_sweep;

    always_comb in_sweep = (off_min_i == off_max_i) && !len_min_i[31];

    // Observer of outstanding requests
    always_ff @(posedge clk) begin
        if (!rst_n)                              pending_q <= 1'b0;
        else if (valid_o)                        pending_q <= 1'b0;
        else if (req_i && cfg_ok_o && !pending_q) pending_q <= 1'b1;
    end

    // Remember the previously issued length and its mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_prev_q  <= 1'b0;
            prev_sweep_q <= 1'b0;
            prev_len_q   <= '0;
        end else if (valid_o) begin
            have_prev_q  <= 1'b1;
            prev_sweep_q <= in_sweep;
            prev_len_q   <= len_o;
        end
    end

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o); // R2
    AST_VALID_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> pending_q); // R2
    AST_OFF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && cfg_ok_o && off_max_i != off_min_i)
        |-> (off_o >= off_min_i && off_o < off_max_i)); // R4
    AST_SWEEP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && in_sweep) |-> off_o == off_min_i); // R5
    AST_SWEEP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && in_sweep && !have_prev_q) |-> len_o == len_min_i); // R6
    AST_SWEEP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && in_sweep && have_prev_q && prev_sweep_q && prev_len_q != len_max_i)
        |-> len_o == prev_len_q + 1); // R6
    AST_SWEEP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && in_sweep && have_prev_q && prev_sweep_q && prev_len_q == len_max_i)
        |-> len_o == len_min_i); // R6
    AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && cfg_ok_o && !in_sweep && !len_min_i[31] && len_max_i != len_min_i)
        |-> (len_o >= len_min_i && len_o < len_max_i)); // R8
    AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(off_o)); // R9
    AST_HOLD_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(len_o)); // R9
endmodule

bind glitch_param_seq gps_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .off_min_i(off_min_i),
    .off_max_i(off_max_i),
    .len_min_i(len_min_i),
    .len_max_i(len_max_i),
    .req_i    (req_i),
    .cfg_ok_o (cfg_ok_o),
    .valid_o  (valid_o),
    .off_o    (off_o),
    .len_o    (len_o)
);

// File: tb/glitch_param_seq_tb.sv
// Directed bench for the glitch parameter sequencer: one task per scenario.
module glitch_param_seq_tb;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [31:0]        off_min = 0, off_max = 0, seed = 32'h1234_5678;
    logic signed [31:0] len_min = 0, len_max = 0;
    logic [11:0]        knob = '0;
    logic               req = 1'b0;
    logic               cfg_ok, valid;
    logic [31:0]        off;
    logic signed [31:0] len;

    int n_checks = 0, n_fails = 0;
    bit done = 1'b0;
    logic [31:0]        m_lfsr;
    logic [31:0]        m_sw;

    always #10 clk = ~clk;   // 50 MHz

    glitch_param_seq u_dut (
        .clk(clk), .rst_n(rst_n), .off_min_i(off_min), .off_max_i(off_max),
        .len_min_i(len_min), .len_max_i(len_max), .seed_i(seed), .knob_i(knob),
        .req_i(req), .cfg_ok_o(cfg_ok), .valid_o(valid), .off_o(off), .len_o(len)
    );

    function automatic logic [31:0] step(input logic [31:0] s);
        return {1'b0, s[31:1]} ^ (s[0] ? 32'h8020_0003 : 32'h0);
    endfunction

    task automatic check(input string tag, input string what, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_lfsr = (seed == 0) ? 32'd1 : seed;
        m_sw   = len_min - 1;
    endtask

    // Issue one request, wait for the strobe and compare against the model
    task automatic issue(input string tag);
        logic [31:0] w1, w2, e_off, e_len, sp;
        bit seen;
        w1 = m_lfsr; w2 = step(w1); m_lfsr = step(w2);
        e_off = off_min + ((off_max == off_min) ? 32'd0 : w1 % (off_max - off_min));
        if (off_min == off_max && len_min >= 0) begin
            m_sw  = (m_sw == len_max) ? len_min : m_sw + 1;
            e_len = m_sw;
        end else if (len_min < 0) begin
            e_len = 32'(((longint'(knob) * longint'(len_max)) >>> 12));
        end else begin
            sp    = len_max - len_min;
            e_len = len_min + ((sp == 0) ? 32'd0 : w2 % sp);
        end
        @(negedge clk); req = 1'b1;
        @(negedge clk); req = 1'b0;
        seen = 1'b0;
        for (int i = 0; i < 100 && !seen; i++) begin
            if (valid) seen = 1'b1; else @(negedge clk);
        end
        check(tag, "valid seen", longint'(seen), 1);
        check(tag, "offset", longint'(off), longint'(e_off));
        check(tag, "length", longint'(len), longint'($signed(e_len)));
        @(negedge clk);
        check("R2", "single pulse", longint'(valid), 0);
    endtask

    task automatic count_valids(input int cycles, output int n);
        n = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (valid) n++;
        end
    endtask

    task automatic t_reset();
        off_min = 1000; off_max = 36000; len_min = 10; len_max = 10000;
        do_reset();
        check("R9", "reset valid", longint'(valid), 0);
        check("R9", "reset offset", longint'(off), 0);
        check("R9", "reset length", longint'(len), 0);
        check("R1", "cfg ok", longint'(cfg_ok), 1);
    endtask

    task automatic t_cfg();
        int n;
        off_min = 500; off_max = 400; len_min = 1; len_max = 2;
        #1 check("R1", "offset max below min", longint'(cfg_ok), 0);
        off_max = 600; len_min = 5; len_max = -3;
        #1 check("R1", "signed length max below min", longint'(cfg_ok), 0);
        @(negedge clk); req = 1'b1; @(negedge clk); req = 1'b0;
        count_valids(60, n);
        check("R2", "refused request gives no pulse", n, 0);
        len_min = -3; len_max = 5;
        #1 check("R1", "negative min below positive max", longint'(cfg_ok), 1);
    endtask

    task automatic t_random();
        off_min = 1000; off_max = 36000; len_min = 10; len_max = 10000;
        do_reset();
        for (int i = 0; i < 5; i++) issue("R4 R8 R3");
        len_min = 77; len_max = 77;
        issue("R8 zero span");
    endtask

    task automatic t_seed_zero();
        seed = 0; off_min = 0; off_max = 32'hFFFF_FFFF; len_min = 0; len_max = 32'h7FFF_FFFF;
        do_reset();
        issue("R3 zero seed");
        issue("R3");
        seed = 32'h1234_5678;
    endtask

    task automatic t_sweep();
        off_min = 500; off_max = 500; len_min = 3; len_max = 6;
        do_reset();
        for (int i = 0; i < 6; i++) issue("R5 R6");
        len_min = 7; len_max = 7;
        do_reset();
        issue("R6 single"); issue("R6 single");
    endtask

    task automatic t_knob();
        off_min = 2000; off_max = 9000; len_min = -1; len_max = 10000;
        do_reset();
        knob = 12'd0;    issue("R7 zero");
        knob = 12'd4095; issue("R7 full");
        knob = 12'd2048; issue("R7 half");
        len_max = 32'sh7FFF_FFFF; knob = 12'd4095; issue("R7 wide product");
        len_min = -100; len_max = -20; knob = 12'd2048; issue("R7 negative scale");
        off_max = 2000; len_min = -1; len_max = 300; knob = 12'd1000; issue("R5 not sweep R7");
    endtask

    task automatic t_busy();
        int n;
        off_min = 100; off_max = 200; len_min = 1; len_max = 50;
        do_reset();
        @(negedge clk); req = 1'b1;
        repeat (3) @(negedge clk);
        req = 1'b0;
        count_valids(80, n);
        check("R2", "one pulse for held request", n, 1);
        m_lfsr = step(step(m_lfsr));
        issue("R2 after busy");
    endtask

    task automatic t_hold();
        logic [31:0] o; logic signed [31:0] l;
        o = off; l = len;
        repeat (20) @(negedge clk);
        check("R9", "offset held", longint'(off), longint'(o));
        check("R9", "length held", longint'(len), longint'(l));
    endtask

    initial begin
        t_reset();
        t_cfg();
        t_random();
        t_seed_zero();
        t_sweep();
        t_knob();
        t_busy();
        t_hold();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end
endmodule